// File: doc/BRIEF.md
# Slot-Wheel Arbiter with Round-Robin Slot Reclaim

This block decides, every clock cycle, which of four bus masters may move one word over a shared bus. Bus time is cut into slots that follow a fixed rotation of eight positions. Each position belongs to one master, or to no master at all. A master can hold several positions, so a parameter table sets how the bandwidth is split.

When the owner of the current position is asking for the bus, it gets the cycle. When the owner is quiet, or the position is a spare, a second stage reclaims the cycle. This stage keeps a pointer to the master it last served. It hands the cycle to the next asking master after that pointer, wrapping around, so reserved time is not lost.

The grant is registered and is never more than one-hot. The rotation moves on by one position every cycle, whatever the request pattern is.

Top module: `slot_wheel_arbiter`

## Requirements
- R1: The request vector is sampled on the rising clock edge. The grant decided from that sample appears on `gnt_o` after the same edge, and it is held for one cycle. A grant bit is set only for a master whose request bit was set in that sample.
- R2: `gnt_o` has at most one bit set in every cycle.
- R3: After reset the rotation stands at position 0. It moves forward by exactly one position on every clock edge and wraps from position 7 to position 0.
- R4: If the owner of the current position has its request bit set, that owner gets the grant (`gnt_o` bit i for master i). The default table is: positions 0, 2 and 4 belong to master 0; positions 1 and 5 to master 1; position 3 to master 2; position 6 to master 3; position 7 is a spare with no owner. Each table entry is 3 bits: bit 2 is the owned flag and bits 1:0 are the master index. Entry k sits at bits 3k+2 down to 3k of `SLOT_TABLE`.
- R5: If the owner of the current position is not requesting, or the position is the spare, the search begins at the master after the reclaim pointer. It goes upward modulo 4 and includes the pointer's own master last. The first requester found gets the grant, and the pointer is set to that master.
- R6: A grant made to the owner of the current position leaves the reclaim pointer unchanged.
- R7: When no request bit is set, `gnt_o` is zero, the rotation still advances, and the reclaim pointer is unchanged.
- R8: While `rst` is high, `gnt_o` is zero. After reset the reclaim pointer stands at master 3, so the first reclaim search begins with master 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Bus request, one bit per master |
| gnt_o | output | 4 | Registered one-hot grant, one bit per master |

## Verification
The bench drives all sixteen request patterns against every rotation position. It then runs a long pseudo-random sequence, and it predicts each grant from its own model of the rotation and the reclaim pointer. This sweep covers three kinds of fault. A design that let owner grants move the pointer would later hand reclaimed cycles to the wrong master. A search that began at the pointer itself, instead of the master after it, would serve one master twice in a row. A rotation that stalled on idle cycles would shift every later owner grant. The spare position is crossed hundreds of times, so a design that treated it as owned by master 0 would grant master 0 out of turn.

// File: rtl/wheel_arb_pkg.sv
`timescale 1ns/1ps
package wheel_arb_pkg;

    localparam int unsigned NUM_MASTERS = 4;
    localparam int unsigned NUM_SLOTS   = 8;
    localparam int unsigned MASTER_W    = $clog2(NUM_MASTERS);
    localparam int unsigned SLOT_W      = $clog2(NUM_SLOTS);

    typedef logic [MASTER_W-1:0]    master_idx_t;
    typedef logic [SLOT_W-1:0]      slot_idx_t;
    typedef logic [NUM_MASTERS-1:0] master_vec_t;

    typedef struct packed {
        logic        owned;
        master_idx_t owner;
    } slot_entry_t;

    localparam int unsigned ENTRY_W = $bits(slot_entry_t);

    typedef struct packed {
        logic        hit;
        master_idx_t idx;
    } pick_t;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_WHEEL,
        SRC_RECLAIM
    } grant_src_t;

    // position 7 spare, 6->m3, 5->m1, 4->m0, 3->m2, 2->m0, 1->m1, 0->m0
    localparam logic [NUM_SLOTS*ENTRY_W-1:0] DEFAULT_TABLE = {
        3'b0_00, 3'b1_11, 3'b1_01, 3'b1_00,
        3'b1_10, 3'b1_00, 3'b1_01, 3'b1_00
    };

    // First requester strictly after ptr, wrapping, ptr itself examined last.
    function automatic pick_t next_requester(master_vec_t req, master_idx_t ptr);
        pick_t res;
        res = '0;
        for (int unsigned i = 1; i <= NUM_MASTERS; i++) begin
            master_idx_t cand;
            cand = master_idx_t'((32'(ptr) + i) % NUM_MASTERS);
            if (!res.hit && req[cand]) begin
                res.hit = 1'b1;
                res.idx = cand;
            end
        end
        return res;
    endfunction

    function automatic master_vec_t to_onehot(master_idx_t idx);
        return master_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/wheel_cursor.sv
`timescale 1ns/1ps
module wheel_cursor
    import wheel_arb_pkg::*;
#(
    parameter logic [NUM_SLOTS*ENTRY_W-1:0] TABLE = DEFAULT_TABLE
) (
    input  logic        clk,
    input  logic        rst,
    output slot_idx_t   cur_slot,
    output slot_entry_t cur_entry
);
    localparam slot_idx_t LAST_SLOT = slot_idx_t'(NUM_SLOTS - 1);

    slot_entry_t entries [NUM_SLOTS];

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_entry
        assign entries[gi] = slot_entry_t'(TABLE[gi*ENTRY_W +: ENTRY_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_slot <= '0;
        end else if (cur_slot == LAST_SLOT) begin
            cur_slot <= '0;
        end else begin
            cur_slot <= cur_slot + slot_idx_t'(1);
        end
    end

    assign cur_entry = entries[cur_slot];

endmodule

// File: rtl/rr_reclaim.sv
`timescale 1ns/1ps
module rr_reclaim
    import wheel_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  master_vec_t req,
    input  logic        reclaim_en,
    output pick_t       pick,
    output master_idx_t rr_ptr
);
    localparam master_idx_t PTR_RESET = master_idx_t'(NUM_MASTERS - 1);

    assign pick = next_requester(req, rr_ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= PTR_RESET;
        end else if (reclaim_en && pick.hit) begin
            rr_ptr <= pick.idx;
        end
    end

endmodule

// File: rtl/slot_wheel_arbiter.sv
`timescale 1ns/1ps
module slot_wheel_arbiter
    import wheel_arb_pkg::*;
#(
    parameter logic [NUM_SLOTS*ENTRY_W-1:0] SLOT_TABLE = DEFAULT_TABLE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] gnt_o
);
    slot_idx_t   cur_slot;
    slot_entry_t cur_entry;
    pick_t       pick;
    master_idx_t rr_ptr;
    logic        owner_req;
    grant_src_t  src;
    master_vec_t gnt_d;

    wheel_cursor #(.TABLE(SLOT_TABLE)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .cur_slot  (cur_slot),
        .cur_entry (cur_entry)
    );

    rr_reclaim u_reclaim (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .reclaim_en (!owner_req),
        .pick       (pick),
        .rr_ptr     (rr_ptr)
    );

    always_comb begin
        owner_req = cur_entry.owned && req_i[cur_entry.owner];
        if (owner_req) begin
            src = SRC_WHEEL;
        end else if (pick.hit) begin
            src = SRC_RECLAIM;
        end else begin
            src = SRC_IDLE;
        end
        case (src)
            SRC_WHEEL:   gnt_d = to_onehot(cur_entry.owner);
            SRC_RECLAIM: gnt_d = to_onehot(pick.idx);
            default:     gnt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_o <= '0;
        end else begin
            gnt_o <= gnt_d;
        end
    end

endmodule

// File: rtl/wheel_arb_checker.sv
`timescale 1ns/1ps
module wheel_arb_checker
    import wheel_arb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input master_vec_t req,
    input master_vec_t gnt,
    input slot_idx_t   cur_slot,
    input slot_entry_t cur_entry,
    input master_idx_t rr_ptr
);
    logic owner_asks;
    assign owner_asks = cur_entry.owned && req[cur_entry.owner];

    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r1_grant_to_requester: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gnt & ~$past(req)) == '0));

    a_r3_wheel_steps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_slot == slot_idx_t'($past(cur_slot) + slot_idx_t'(1))));

    a_r4_owner_granted: assert property (@(posedge clk) disable iff (rst)
        owner_asks |=> (gnt == (master_vec_t'(1) << $past(cur_entry.owner))));

    a_r5_reclaim_moves_ptr: assert property (@(posedge clk) disable iff (rst)
        (!owner_asks && (req != '0)) |=> gnt[rr_ptr]);

    a_r6_owner_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        owner_asks |=> $stable(rr_ptr));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> ((gnt == '0) && $stable(rr_ptr)));

endmodule

bind slot_wheel_arbiter wheel_arb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req_i),
    .gnt       (gnt_o),
    .cur_slot  (cur_slot),
    .cur_entry (cur_entry),
    .rr_ptr    (rr_ptr)
);

// File: tb/slot_wheel_arbiter_bench.sv
`timescale 1ns/1ps
module slot_wheel_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_i = 4'b0;
    logic [3:0] gnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_slot = 0;
    int m_ptr  = 3;

    always #5 clk = ~clk;

    slot_wheel_arbiter u_slot_wheel_arbiter (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_i),
        .gnt_o (gnt_o)
    );

    // Ownership per R4: returns -1 for the spare position.
    function automatic int owner_of(int s);
        case (s)
            0, 2, 4: return 0;
            1, 5:    return 1;
            3:       return 2;
            6:       return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: gnt_o=%b expected=%b (slot %0d)", tag, got, exp, m_slot);
        end
    endtask

    task automatic step(logic [3:0] r);
        logic [3:0] exp;
        string      tag;
        int         own;
        int         nxt_ptr;
        req_i   = r;
        own     = owner_of(m_slot);
        exp     = 4'b0;
        nxt_ptr = m_ptr;
        if (own >= 0 && r[own]) begin
            exp = 4'b1 << own;
            tag = "R1,R3,R4,R6";
        end else begin
            tag = "R1,R3,R7";
            for (int i = 1; i <= 4; i++) begin
                int c;
                c = (m_ptr + i) % 4;
                if (exp == 4'b0 && r[c]) begin
                    exp     = 4'b1 << c;
                    nxt_ptr = c;
                    tag     = "R1,R3,R5";
                end
            end
        end
        @(posedge clk);
        #1;
        check(tag, gnt_o, exp);
        checks++;
        if ($countones(gnt_o) > 1) begin
            fails++;
            $display("FAIL R2: gnt_o=%b expected at most one bit", gnt_o);
        end
        m_ptr  = nxt_ptr;
        m_slot = (m_slot + 1) % 8;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R8", gnt_o, 4'b0);
        @(negedge clk);
        rst = 1'b0;

        // R8: first reclaim search begins at master 0 (pointer at master 3)
        step(4'b0000);            // slot 0, nothing
        step(4'b1101);            // slot 1 owner m1 idle -> m0 reclaimed

        // R6/R7 directed: owner grants and idle cycles then a reclaim
        step(4'b0001);            // slot 2 owner m0 grant, pointer stays 0
        step(4'b0000);            // slot 3 idle
        step(4'b1010);            // slot 4 owner m0 idle -> m1 after ptr 0

        // Exhaustive: every pattern at every rotation position, twice
        for (int pass = 0; pass < 2; pass++) begin
            for (int p = 0; p < 16; p++) begin
                for (int s = 0; s < 8; s++) begin
                    step(4'(p ^ (pass * 5)));
                end
            end
        end

        // Pseudo-random sequence
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0] & (lfsr[7] ? 4'hF : lfsr[11:8]));
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R1: watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule